// File: doc/BRIEF.md
# Elastic FIFO with Burst Write

A register-based first-in first-out buffer that lets a producer and a consumer run at different rates within one clock domain. The storage holds a power-of-two number of entries, addressed by a write pointer and a read pointer that both wrap freely. The fill level is not kept in its own counter. It is computed from the two pointers alone.

Three request/acknowledge operations share the buffer: a single-item write, a burst write that places up to `DEPTH-2` items in one operation, and a single-item read. Every request is held by the requester until the block acknowledges it. The block acknowledges only once its occupancy rule allows it, so a request that cannot proceed stalls. The write side keeps two entries of head-room, so the level never rises above `DEPTH-2`. A burst is presented most-significant item first and is stored in reverse. The item presented last is therefore read out first.

Top module: `eb_fifo`

## Requirements
- R1: After reset every storage entry and both pointers are zero. `fill_level` reads 0, and `rd_ack`, `bst_ack` and `bst_err` are low.
- R2: `fill_level` equals (write pointer − read pointer) mod `DEPTH`, and it tracks every accepted operation, including across pointer wrap-around.
- R3: A single write is acknowledged (`wr_ack` high in the same cycle as `wr_req`) only while `fill_level < DEPTH-2`. On that clock edge the item is stored at the write pointer and the write pointer advances by one.
- R4: A burst with length L in 1..`DEPTH-2` is accepted only while `fill_level + L < DEPTH-1`. Otherwise it waits.
- R5: Burst field j (bits `j*DW +: DW` of `bst_data`, with field 0 being the item presented last) is stored at (write pointer + j) mod `DEPTH`. Reads therefore return field 0 first and field L−1 last.
- R6: All burst entries are written on the accept edge. The write pointer advances by L on the next edge. `bst_ack` is high for exactly one cycle, which is the cycle after that advance, two cycles after acceptance. From that cycle on, `fill_level` includes the L items.
- R7: A read is acknowledged only while `fill_level != 0`. `rd_data` shows the entry at the read pointer, and the read pointer advances by one on the acknowledged edge.
- R8: A burst request with L = 0 or L > `DEPTH-2` is rejected. `bst_err` is high in each cycle in which such a request is seen while the burst engine is idle, and the fill level is not changed by it.
- R9: A write and a read acknowledged in the same cycle both take effect, and `fill_level` is unchanged.
- R10: `fill_level` never exceeds `DEPTH-2`.
- R11: While the burst engine is busy, or while any burst request is present, single writes are not acknowledged. Bursts have priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Single write request |
| wr_data | input | DW | Single write item |
| wr_ack | output | 1 | Single write taken on this edge |
| bst_req | input | 1 | Burst write request |
| bst_len | input | $clog2(DEPTH) | Burst item count |
| bst_data | input | (DEPTH-2)*DW | Burst items; field 0 = item presented last |
| bst_ack | output | 1 | Burst completed (one-cycle pulse) |
| bst_err | output | 1 | Burst length rejected |
| rd_req | input | 1 | Read request |
| rd_data | output | DW | Entry at the read pointer |
| rd_ack | output | 1 | Read taken on this edge |
| fill_level | output | $clog2(DEPTH) | Occupancy derived from the pointers |

## Verification
A sweep runs a burst of every legal length from every starting level that allows it, and then drains the buffer. This separates a wrong acceptance threshold from a wrong field placement, and because the pointers keep moving it also covers every wrap position. Directed cases hold requests at the exact full margins, send illegal lengths, overlap a write with a read, and raise a single write together with a burst. A random mix of all three operations, checked against a queue model, then looks for ordering errors that only appear when operations interleave.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

    // burst engine phases: accept -> advance pointer -> acknowledge
    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_ADV  = 2'd1,
        BST_DONE = 2'd2
    } bst_state_e;

endpackage

// File: rtl/eb_occupancy.sv
module eb_occupancy #(
    parameter int DEPTH = 16,
    parameter int N     = $clog2(DEPTH)
) (
    input  logic [N-1:0] wp,
    input  logic [N-1:0] rp,
    output logic [N-1:0] level
);
    localparam logic [N:0] DEPTH_X = (N+1)'(DEPTH);

    logic [N:0] sum_x;

    // one extra bit so the sum cannot overflow before the modulo
    always_comb begin
        sum_x = {1'b0, wp} + DEPTH_X - {1'b0, rp};
        level = sum_x[N-1:0];
    end
endmodule

// File: rtl/eb_store.sv
module eb_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int N     = $clog2(DEPTH),
    parameter int MAXB  = DEPTH - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_we,
    input  logic [N-1:0]      wp,
    input  logic [DW-1:0]     wr_data,
    input  logic              burst_we,
    input  logic [N-1:0]      burst_len,
    input  logic [MAXB*DW-1:0] burst_data,
    input  logic [N-1:0]      rp,
    output logic [DW-1:0]     rd_data
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] field_pad [DEPTH];
    logic          hit     [DEPTH];
    logic [DW-1:0] hit_val [DEPTH];

    // burst fields padded to DEPTH so any offset indexes safely
    for (genvar f = 0; f < DEPTH; f++) begin : g_pad
        if (f < MAXB) begin : g_used
            assign field_pad[f] = burst_data[f*DW +: DW];
        end else begin : g_zero
            assign field_pad[f] = '0;
        end
    end

    // per-entry burst decode: offset from the write pointer
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam logic [N-1:0] EI = N'(e);
        logic [N-1:0] off;
        assign off        = EI - wp;
        assign hit[e]     = burst_we && (off < burst_len);
        assign hit_val[e] = field_pad[off];
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (hit[i]) mem_d[i] = hit_val[i];
        end
        if (single_we) mem_d[wp] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rp];
endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl
    import efifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int N     = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic         bst_req,
    input  logic [N-1:0] bst_len,
    input  logic         rd_req,
    input  logic [N-1:0] level,
    output logic         wr_ack,
    output logic         bst_go,
    output logic         bst_ack,
    output logic         bst_err,
    output logic         rd_ack,
    output logic [N-1:0] wp,
    output logic [N-1:0] rp
);
    localparam logic [N:0] MAXB_X   = (N+1)'(DEPTH - 2);
    localparam logic [N:0] BST_LIM  = (N+1)'(DEPTH - 1);
    localparam logic [N:0] WR_LIM   = (N+1)'(DEPTH - 2);

    typedef struct packed {
        bst_state_e   st;
        logic [N-1:0] wp;
        logic [N-1:0] rp;
        logic [N-1:0] len;
    } ctrl_t;

    ctrl_t s_q, s_d;
    logic  idle, len_ok;
    logic [N:0] lvl_x, len_x;

    always_comb begin
        s_d    = s_q;
        lvl_x  = {1'b0, level};
        len_x  = {1'b0, bst_len};
        idle   = (s_q.st == BST_IDLE);
        len_ok = (bst_len != '0) && (len_x <= MAXB_X);

        bst_go  = idle && bst_req && len_ok && ((lvl_x + len_x) < BST_LIM);
        bst_err = idle && bst_req && !len_ok;
        wr_ack  = idle && !bst_req && wr_req && (lvl_x < WR_LIM);
        rd_ack  = rd_req && (level != '0);
        bst_ack = (s_q.st == BST_DONE);

        if (wr_ack) s_d.wp = s_q.wp + N'(1);
        if (rd_ack) s_d.rp = s_q.rp + N'(1);

        unique case (s_q.st)
            BST_IDLE: if (bst_go) begin
                s_d.st  = BST_ADV;
                s_d.len = bst_len;
            end
            BST_ADV: begin
                s_d.wp = s_q.wp + s_q.len;
                s_d.st = BST_DONE;
            end
            BST_DONE: s_d.st = BST_IDLE;
            default:  s_d.st = BST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= BST_IDLE;
            s_q.wp  <= '0;
            s_q.rp  <= '0;
            s_q.len <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wp = s_q.wp;
    assign rp = s_q.rp;
endmodule

// File: rtl/eb_fifo.sv
module eb_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int N     = $clog2(DEPTH),
    parameter int MAXB  = DEPTH - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [DW-1:0]      wr_data,
    output logic               wr_ack,
    input  logic               bst_req,
    input  logic [N-1:0]       bst_len,
    input  logic [MAXB*DW-1:0] bst_data,
    output logic               bst_ack,
    output logic               bst_err,
    input  logic               rd_req,
    output logic [DW-1:0]      rd_data,
    output logic               rd_ack,
    output logic [N-1:0]       fill_level
);
    logic [N-1:0] wp, rp;
    logic         bst_go;

    eb_occupancy #(.DEPTH(DEPTH), .N(N)) u_occ (
        .wp(wp), .rp(rp), .level(fill_level)
    );

    eb_ctrl #(.DEPTH(DEPTH), .N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .bst_req(bst_req), .bst_len(bst_len), .rd_req(rd_req),
        .level(fill_level),
        .wr_ack(wr_ack), .bst_go(bst_go), .bst_ack(bst_ack), .bst_err(bst_err),
        .rd_ack(rd_ack), .wp(wp), .rp(rp)
    );

    eb_store #(.DW(DW), .DEPTH(DEPTH), .N(N), .MAXB(MAXB)) u_store (
        .clk(clk), .rst_n(rst_n),
        .single_we(wr_ack), .wp(wp), .wr_data(wr_data),
        .burst_we(bst_go), .burst_len(bst_len), .burst_data(bst_data),
        .rp(rp), .rd_data(rd_data)
    );
endmodule

// File: rtl/eb_fifo_chk.sv
module eb_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int N     = $clog2(DEPTH)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_ack,
    input logic         rd_ack,
    input logic         bst_ack,
    input logic         bst_err,
    input logic [N-1:0] fill_level
);
    localparam logic [N-1:0] CAP = N'(DEPTH - 2);

    p_level_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CAP);

    p_read_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> fill_level != '0);

    p_write_margin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> fill_level < CAP);

    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bst_ack |=> !bst_ack);

    p_err_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_err && !rd_ack) |=> $stable(fill_level));

    p_rw_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && rd_ack) |=> $stable(fill_level));

    p_burst_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bst_ack |-> !wr_ack);
endmodule

bind eb_fifo eb_fifo_chk #(.DEPTH(DEPTH), .N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_ack(wr_ack), .rd_ack(rd_ack),
    .bst_ack(bst_ack), .bst_err(bst_err), .fill_level(fill_level)
);

// File: tb/eb_fifo_tb_top.sv
module eb_fifo_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int N     = $clog2(DEPTH);
    localparam int MAXB  = DEPTH - 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_req = 1'b0;
    logic [DW-1:0]      wr_data = '0;
    logic               wr_ack;
    logic               bst_req = 1'b0;
    logic [N-1:0]       bst_len = '0;
    logic [MAXB*DW-1:0] bst_data = '0;
    logic               bst_ack, bst_err;
    logic               rd_req = 1'b0;
    logic [DW-1:0]      rd_data;
    logic               rd_ack;
    logic [N-1:0]       fill_level;

    always #2.5 clk = ~clk;

    eb_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

    int vectors = 0;
    int fails   = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] seq = 8'h01;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // wait at the sampling point until flag rises; false on timeout
    task automatic wait_hi(ref logic sig, output bit ok);
        ok = 1'b1;
        for (int t = 0; !sig; t++) begin
            if (t > 40) begin ok = 1'b0; return; end
            @(negedge clk); #1;
        end
    endtask

    task automatic wr1(input logic [DW-1:0] d);
        bit ok;
        @(negedge clk); wr_req = 1'b1; wr_data = d; #1;
        wait_hi(wr_ack, ok);
        chk(ok, "R3 write ack", int'(ok), 1);
        chk(int'(fill_level) < DEPTH-2, "R3 margin", int'(fill_level), DEPTH-3);
        q.push_back(d);
        @(negedge clk); wr_req = 1'b0; #1;
        chk(int'(fill_level) == q.size(), "R2 level after write", int'(fill_level), q.size());
    endtask

    task automatic rd1;
        bit ok;
        logic [DW-1:0] exp;
        @(negedge clk); rd_req = 1'b1; #1;
        wait_hi(rd_ack, ok);
        chk(ok, "R7 read ack", int'(ok), 1);
        exp = q.pop_front();
        chk(rd_data == exp, "R7/R5 read data", int'(rd_data), int'(exp));
        @(negedge clk); rd_req = 1'b0; #1;
        chk(int'(fill_level) == q.size(), "R2 level after read", int'(fill_level), q.size());
        chk(int'(fill_level) <= DEPTH-2, "R10 cap", int'(fill_level), DEPTH-2);
    endtask

    // burst of L items; fields filled from seq, field 0 = last presented
    task automatic burst(input int L);
        int cyc, lvl0;
        logic [MAXB*DW-1:0] flat;
        flat = '0;
        for (int j = 0; j < L; j++) begin flat[j*DW +: DW] = seq; seq++; end
        lvl0 = q.size();
        @(negedge clk); bst_req = 1'b1; bst_len = N'(L); bst_data = flat; #1;
        chk(wr_ack == 1'b0, "R11 no single write under burst", int'(wr_ack), 0);
        cyc = 0;
        while (!bst_ack && cyc < 40) begin
            chk(int'(fill_level) == lvl0, "R6 level before ack", int'(fill_level), lvl0);
            @(negedge clk); #1; cyc++;
        end
        chk(cyc == 2, "R6 ack two cycles after accept", cyc, 2);
        chk(int'(fill_level) == lvl0 + L, "R6 level at ack", int'(fill_level), lvl0 + L);
        for (int j = 0; j < L; j++) q.push_back(flat[j*DW +: DW]);
        @(negedge clk); bst_req = 1'b0; #1;
        chk(bst_ack == 1'b0, "R6 ack one cycle", int'(bst_ack), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(fill_level == '0, "R1 reset level", int'(fill_level), 0);
        rd_req = 1'b1; #0.5;
        chk(rd_ack == 1'b0, "R1 empty read blocked", int'(rd_ack), 0);
        chk(rd_data == '0, "R1 entry zero", int'(rd_data), 0);
        rd_req = 1'b0;
        chk(bst_ack == 1'b0 && bst_err == 1'b0, "R1 burst flags low", int'(bst_ack), 0);
        @(negedge clk); rst_n = 1'b1;

        // R5 directed: items presented A,B,C -> read C,B,A
        begin
            @(negedge clk); bst_req = 1'b1; bst_len = N'(3);
            bst_data = '0;
            bst_data[2*DW +: DW] = 8'hA1; bst_data[DW +: DW] = 8'hB2; bst_data[0 +: DW] = 8'hC3;
            while (!bst_ack) begin @(negedge clk); #1; end
            @(negedge clk); bst_req = 1'b0;
            q.push_back(8'hC3); q.push_back(8'hB2); q.push_back(8'hA1);
            rd1(); rd1(); rd1();
        end

        // R3: block at the margin
        for (int i = 0; i < DEPTH-2; i++) begin wr1(seq); seq++; end
        @(negedge clk); wr_req = 1'b1; wr_data = 8'hEE;
        for (int c = 0; c < 4; c++) begin
            #1; chk(wr_ack == 1'b0, "R3 blocked at DEPTH-2", int'(wr_ack), 0);
            @(negedge clk);
        end
        wr_req = 1'b0;
        #1; chk(int'(fill_level) == DEPTH-2, "R10 level held", int'(fill_level), DEPTH-2);

        // R4: burst blocked when level + L >= DEPTH-1
        rd1(); rd1();                 // level 12
        @(negedge clk); bst_req = 1'b1; bst_len = N'(3);
        for (int c = 0; c < 4; c++) begin
            #1; chk(bst_ack == 1'b0 && fill_level == N'(12), "R4 burst blocked", int'(fill_level), 12);
            @(negedge clk);
        end
        bst_req = 1'b0;
        burst(2);                     // 12 + 2 < 15 accepted -> 14

        // R8: illegal lengths
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); bst_req = 1'b1; bst_len = (k == 0) ? N'(0) : N'(DEPTH-1); #1;
            chk(bst_err == 1'b1, "R8 reject flag", int'(bst_err), 1);
            @(negedge clk); bst_req = 1'b0; #1;
            chk(bst_err == 1'b0 && int'(fill_level) == q.size(), "R8 no effect", int'(fill_level), q.size());
        end
        while (q.size() > 0) rd1();

        // R9: write and read in the same cycle
        wr1(8'h55); wr1(8'h66);
        @(negedge clk); wr_req = 1'b1; wr_data = 8'h77; rd_req = 1'b1; #1;
        chk(wr_ack && rd_ack, "R9 both acked", int'(wr_ack & rd_ack), 1);
        chk(rd_data == q[0], "R9 read data", int'(rd_data), int'(q[0]));
        void'(q.pop_front()); q.push_back(8'h77);
        @(negedge clk); wr_req = 1'b0; rd_req = 1'b0; #1;
        chk(int'(fill_level) == 2, "R9 level unchanged", int'(fill_level), 2);

        // R11: simultaneous single write and burst request
        @(negedge clk); wr_req = 1'b1; wr_data = 8'h99; bst_req = 1'b1; bst_len = N'(1);
        bst_data = '0; bst_data[0 +: DW] = 8'h88; #1;
        chk(wr_ack == 1'b0, "R11 burst wins", int'(wr_ack), 0);
        bst_req = 1'b1;
        while (!bst_ack) begin
            #0; chk(wr_ack == 1'b0, "R11 write held off", int'(wr_ack), 0);
            @(negedge clk); #1;
        end
        q.push_back(8'h88);
        @(negedge clk); bst_req = 1'b0; #1;
        while (!wr_ack) begin @(negedge clk); #1; end
        q.push_back(8'h99);
        @(negedge clk); wr_req = 1'b0;
        while (q.size() > 0) rd1();

        // R4/R5/R2: sweep start level and burst length, drain each time
        for (int s = 0; s <= DEPTH-3; s++) begin
            for (int L = 1; s + L <= DEPTH-2; L++) begin
                for (int i = 0; i < s; i++) begin wr1(seq); seq++; end
                burst(L);
                while (q.size() > 0) rd1();
            end
        end

        // random mix against the queue model
        for (int n = 0; n < 400; n++) begin
            int op, L;
            op = int'($urandom_range(0, 2));
            L  = int'($urandom_range(1, DEPTH-2));
            if (op == 0 && q.size() < DEPTH-2) begin wr1(seq); seq++; end
            else if (op == 1 && q.size() + L < DEPTH-1) burst(L);
            else if (q.size() > 0) rd1();
        end
        while (q.size() > 0) rd1();

        summary();
        $finish;
    end
endmodule